// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit watches the synchronized inputs of one 32-pin GPIO bank and turns pin activity into interrupt requests. Each pin is given one of five trigger modes: low level, high level, falling edge, rising edge or both edges. Every detected event is latched in a sticky status bit. A per-pin mask decides whether that bit reaches the single combined interrupt line. Software reaches all of this through the same simple write/read register bus the bank uses.

The trigger mode of a pin is decoded into an enumerated mode. The five modes are `TRIG_LVL_LOW`, `TRIG_LVL_HIGH`, `TRIG_EDGE_FALL`, `TRIG_EDGE_RISE` and `TRIG_EDGE_BOTH`. A `unique case` on that mode picks the event condition. The mode changes only when software rewrites the configuration registers. There is no other sequencing.

Detection never stops for a masked pin; the mask blocks propagation only. For that reason software usually clears a pin's status bit before it unmasks the pin.

The mask is never written directly. Writing ones to an unmask port clears mask bits, and writing ones to a mask port sets them. The resulting mask can be read back.

Register map (bus offsets), with bit n belonging to pin n:
- 0x20C mask (read only, 1 = masked)
- 0x210 unmask strobe (write-1 clears mask bits, reads 0)
- 0x214 mask strobe (write-1 sets mask bits, reads 0)
- 0x218 status (read, write-1-to-clear)
- 0x21C type (1 = edge, 0 = level)
- 0x220 polarity (1 = rising/high, 0 = falling/low)
- 0x224 any-edge (1 = both edges, for edge-sensitive pins)

Top module: `gpio_irq_unit`

## Requirements
- R1: During and right after reset every mask bit is 1, every status bit is 0, the type, polarity and any-edge registers read 0, the edge history register is 0, and `irq_out` is low.
- R2: A pin with type=1, polarity=1, any-edge=0 sets its status bit at the first clock edge where its input is 1 and was 0 on the previous edge; a falling transition sets nothing.
- R3: A pin with type=1, polarity=0, any-edge=0 sets its status bit on a 1-to-0 transition only.
- R4: A pin with type=1 and any-edge=1 sets its status bit on either transition, whatever its polarity bit holds.
- R5: A pin with type=0 sets its status bit on every clock edge where its input equals its polarity bit, so a clear only sticks while that level is absent.
- R6: The any-edge bit has no effect on a pin with type=0.
- R7: Writing 1 to a bit of the status register (0x218) clears it at that clock edge; writing 0 leaves the bit unchanged, and a status bit otherwise stays set.
- R8: Writing ones to 0x210 clears the matching mask bits, writing ones to 0x214 sets them, zero bits change nothing, and the mask reads back at 0x20C with 1 meaning masked.
- R9: Status capture continues for masked pins, and a bit captured while masked drives `irq_out` once its pin is unmasked, unless it was cleared first.
- R10: `irq_out` is high exactly when some status bit is set whose mask bit is 0.
- R11: When an event and a write-1 clear hit the same status bit at the same clock edge, the bit stays set.
- R12: The type (0x21C), polarity (0x220) and any-edge (0x224) registers read back what was written, and the two strobe offsets and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin levels, bit n is pin n |
| bus_wr | input | 1 | Write strobe, acts at the rising clock edge |
| bus_addr | input | 12 | Byte offset for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench aims at the collision of an edge with a write-1 clear of the same bit. A design that gives the clear priority would lose that event. It also checks a level-sensitive pin whose clear must not stick while the level is still present; a design that set status only on level changes would fail there. It unmasks a pin whose event arrived while it was masked, which catches a design that gates detection instead of propagation. It drives a falling edge on a both-edges pin that has polarity set, and a low level on a level pin with any-edge set. These catch logic that lets the polarity or any-edge bit leak into the wrong mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam logic [11:0] OFF_MASK   = 12'h20C;
    localparam logic [11:0] OFF_UNMASK = 12'h210;
    localparam logic [11:0] OFF_SETMSK = 12'h214;
    localparam logic [11:0] OFF_STATUS = 12'h218;
    localparam logic [11:0] OFF_TYPE   = 12'h21C;
    localparam logic [11:0] OFF_POL    = 12'h220;
    localparam logic [11:0] OFF_ANY    = 12'h224;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW   = 3'd0,
        TRIG_LVL_HIGH  = 3'd1,
        TRIG_EDGE_FALL = 3'd2,
        TRIG_EDGE_RISE = 3'd3,
        TRIG_EDGE_BOTH = 3'd4
    } trig_mode_e;

    function automatic trig_mode_e decode_mode(input logic is_edge,
                                               input logic pol,
                                               input logic any);
        trig_mode_e m;
        if (!is_edge)
            m = pol ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
        else if (any)
            m = TRIG_EDGE_BOTH;
        else
            m = pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
        return m;
    endfunction

endpackage

// File: rtl/gir_cfg_regs.sv
module gir_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] type_o,
    output logic [N_PINS-1:0] pol_o,
    output logic [N_PINS-1:0] any_o,
    output logic [N_PINS-1:0] mask_o,
    output logic [N_PINS-1:0] clr_o
);

    logic [N_PINS-1:0] type_q, pol_q, any_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= '0;
            pol_q  <= '0;
            any_q  <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                OFF_TYPE:   type_q <= wr_data;
                OFF_POL:    pol_q  <= wr_data;
                OFF_ANY:    any_q  <= wr_data;
                OFF_UNMASK: mask_q <= mask_q & ~wr_data;
                OFF_SETMSK: mask_q <= mask_q | wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_en && (wr_addr == OFF_STATUS))
            clr_o = wr_data;
    end

    assign type_o = type_q;
    assign pol_o  = pol_q;
    assign any_o  = any_q;
    assign mask_o = mask_q;

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_UNMASK) |=> ((mask_q & $past(wr_data)) == '0)); // R8
    AST_SETMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_SETMSK) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R8
    AST_MASK_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == OFF_UNMASK || wr_addr == OFF_SETMSK)) |=> $stable(mask_q)); // R8

endmodule

// File: rtl/gir_pin_detect.sv
module gir_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic is_edge_i,
    input  logic pol_i,
    input  logic any_i,
    output logic event_o
);

    logic       prev_q;
    trig_mode_e mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    assign mode = decode_mode(is_edge_i, pol_i, any_i);

    always_comb begin
        unique case (mode)
            TRIG_LVL_LOW:   event_o = ~pin_i;
            TRIG_LVL_HIGH:  event_o = pin_i;
            TRIG_EDGE_FALL: event_o = prev_q & ~pin_i;
            TRIG_EDGE_RISE: event_o = ~prev_q & pin_i;
            TRIG_EDGE_BOTH: event_o = prev_q ^ pin_i;
            default:        event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gir_status.sv
module gir_status #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] event_i,
    input  logic [N_PINS-1:0] clr_i,
    input  logic [N_PINS-1:0] mask_i,
    output logic [N_PINS-1:0] status_o,
    output logic              irq_o
);

    logic [N_PINS-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | event_i;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & ~mask_i);

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((status_q & $past(event_i)) == $past(event_i))); // R11
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_q & $past(clr_i & ~event_i)) == '0)); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R9

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic              irq_out
);

    logic [N_PINS-1:0] type_r, pol_r, any_r, mask_r, clr_w, event_w, status_r;

    gir_cfg_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .type_o  (type_r),
        .pol_o   (pol_r),
        .any_o   (any_r),
        .mask_o  (mask_r),
        .clr_o   (clr_w)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        gir_pin_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_in[p]),
            .is_edge_i (type_r[p]),
            .pol_i     (pol_r[p]),
            .any_i     (any_r[p]),
            .event_o   (event_w[p])
        );
    end

    gir_status #(.N_PINS(N_PINS)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (event_w),
        .clr_i    (clr_w),
        .mask_i   (mask_r),
        .status_o (status_r),
        .irq_o    (irq_out)
    );

    always_comb begin
        case (bus_addr)
            OFF_MASK:   bus_rdata = mask_r;
            OFF_STATUS: bus_rdata = status_r;
            OFF_TYPE:   bus_rdata = type_r;
            OFF_POL:    bus_rdata = pol_r;
            OFF_ANY:    bus_rdata = any_r;
            default:    bus_rdata = '0;
        endcase
    end

    AST_IRQ_QUIET_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_r == '0) |-> !irq_out); // R10
    AST_IRQ_QUIET_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_r) |-> !irq_out); // R9

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;

    localparam logic [11:0] A_MASK = 12'h20C, A_UNM = 12'h210, A_SETM = 12'h214;
    localparam logic [11:0] A_ST = 12'h218, A_TYP = 12'h21C, A_POL = 12'h220, A_ANY = 12'h224;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] pins;
        logic [31:0] exp_st;
        logic        exp_irq;
    } step_t;

    localparam int NSTEP = 24;
    localparam step_t VEC [NSTEP] = '{
        '{1'b1, 12'h21C, 32'h07, 32'hFFFFFFFF, 32'h00, 1'b0},
        '{1'b1, 12'h220, 32'h0D, 32'hFFFFFFFF, 32'h00, 1'b0},
        '{1'b1, 12'h224, 32'h14, 32'hFFFFFFFF, 32'h08, 1'b0},
        '{1'b1, 12'h218, 32'h08, 32'hFFFFFFF7, 32'h00, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF6, 32'h00, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF7, 32'h01, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF5, 32'h03, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF7, 32'h03, 1'b0},
        '{1'b1, 12'h218, 32'h03, 32'hFFFFFFF7, 32'h00, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF3, 32'h04, 1'b0},
        '{1'b1, 12'h218, 32'h04, 32'hFFFFFFF7, 32'h04, 1'b0},
        '{1'b1, 12'h218, 32'h04, 32'hFFFFFFF7, 32'h00, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFFF, 32'h08, 1'b0},
        '{1'b1, 12'h218, 32'h08, 32'hFFFFFFFF, 32'h08, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFE7, 32'h18, 1'b0},
        '{1'b1, 12'h218, 32'h18, 32'hFFFFFFFF, 32'h08, 1'b0},
        '{1'b1, 12'h218, 32'h00, 32'hFFFFFFF7, 32'h08, 1'b0},
        '{1'b1, 12'h210, 32'h08, 32'hFFFFFFF7, 32'h08, 1'b1},
        '{1'b1, 12'h214, 32'h08, 32'hFFFFFFF7, 32'h08, 1'b0},
        '{1'b1, 12'h210, 32'h01, 32'hFFFFFFF7, 32'h08, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF6, 32'h08, 1'b0},
        '{1'b0, 12'h218, 32'h00, 32'hFFFFFFF7, 32'h09, 1'b1},
        '{1'b1, 12'h218, 32'h01, 32'hFFFFFFF7, 32'h08, 1'b0},
        '{1'b1, 12'h218, 32'h08, 32'hFFFFFFF7, 32'h00, 1'b0}
    };

    function automatic string step_req(input int i);
        case (i)
            0, 1:               return "R12";
            2, 12, 13, 15:      return "R5";
            3, 8, 11, 16, 22:   return "R7";
            4, 5, 20:           return "R2";
            6, 7:               return "R3";
            9:                  return "R4";
            10:                 return "R11";
            14:                 return "R6";
            17:                 return "R9";
            18:                 return "R8";
            default:            return "R10";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = 32'hFFFFFFFF;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Called at a falling edge: drive, take one rising edge, return at next falling edge.
    task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] p);
        pin_in = p;
        bus_wr = w;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before any clock edge
        rd(A_MASK, r); chk("R1 mask", r, 32'hFFFFFFFF);
        rd(A_ST, r);   chk("R1 status", r, 32'h0);
        rd(A_TYP, r);  chk("R1 type", r, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        for (int i = 0; i < NSTEP; i++) begin
            step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].pins);
            rd(A_ST, r);
            chk(step_req(i), r, VEC[i].exp_st);
            chk(step_req(i), {31'b0, irq_out}, {31'b0, VEC[i].exp_irq});
        end

        rd(A_MASK, r); chk("R8 mask readback", r, 32'hFFFFFFFE);
        rd(A_TYP, r);  chk("R12 type readback", r, 32'h07);
        rd(A_POL, r);  chk("R12 polarity readback", r, 32'h0D);
        rd(A_ANY, r);  chk("R12 any readback", r, 32'h14);
        rd(A_UNM, r);  chk("R12 unmask strobe reads 0", r, 32'h0);
        rd(A_SETM, r); chk("R12 mask strobe reads 0", r, 32'h0);

        // R5: top pin still in reset level-low mode
        step(1'b0, A_ST, 32'h0, 32'h7FFFFFF7);
        rd(A_ST, r); chk("R5 pin31 level low", r, 32'h80000000);
        chk("R10 pin31 masked irq", {31'b0, irq_out}, 32'h0);
        step(1'b1, A_ST, 32'h80000000, 32'hFFFFFFF7);
        rd(A_ST, r); chk("R7 pin31 cleared", r, 32'h0);

        // R1: reset in the middle of activity
        step(1'b1, A_UNM, 32'h80000000, 32'h7FFFFFF7);
        chk("R10 pin31 unmasked irq", {31'b0, irq_out}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_ST, r);   chk("R1 status after rerun reset", r, 32'h0);
        rd(A_MASK, r); chk("R1 mask after rerun reset", r, 32'hFFFFFFFF);
        rd(A_POL, r);  chk("R1 polarity after rerun reset", r, 32'h0);
        chk("R1 irq after rerun reset", {31'b0, irq_out}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule